// File: doc/BRIEF.md
# Queued Full-Duplex SPI Master

This block is a serial-bus master that sits behind a memory-mapped data register. Host writes put bytes into a four-entry transmit queue. A single-byte write strobe enqueues one byte. A halfword write strobe enqueues two bytes, which go out as two 8-bit frames one after the other. The shift engine takes the oldest queued byte as soon as it is idle and clocks it out on MOSI, most significant bit first. SCK idles low, and MISO is captured on each rising SCK edge. Each frame therefore also yields one received byte, which enters a four-entry receive queue. A host read returns the oldest received byte and removes it.

The SCK rate is the system clock divided by a fixed ratio (128 by default). Chip select is not part of this block; the host drives it separately. Four status outputs are provided. One flag says the transmit queue can take more data. A second says received data is waiting, with a choice of one or two bytes as the threshold. A third says traffic is still in progress. A fourth is a sticky flag that records a received byte lost to a full receive queue.

Top module: `spim_ctrl`

## Requirements
- R1: Out of reset, sck and mosi are 0, txe is 1, and rxne, bsy and ovr are 0.
- R2: When the engine is idle, a byte that enters the transmit queue at a clock edge is loaded at the next edge. The frame lasts 8*DIV clocks and contains exactly 8 SCK periods. In each period SCK is low for the first DIV/2 clocks and high for the next DIV/2.
- R3: SCK is 0 whenever no frame is running. MOSI carries the frame's bits MSB first from the load edge onward, and changes only on the edges where SCK falls. MISO is captured on the edges where SCK rises.
- R4: A wr_half write enqueues wdata[7:0] first and then wdata[15:8]. The two frames run back to back, with the second loaded on the edge that ends the first.
- R5: The transmit queue holds 4 bytes. A write's low byte is accepted only if at least one entry is free, and a halfword's high byte only if at least two are free. This is judged on the occupancy before that edge. Bytes that do not fit are dropped and never sent.
- R6: txe is 1 exactly while the transmit queue holds fewer than 2 bytes.
- R7: With rx_thr_one = 1, rxne is 1 while the receive queue holds at least 1 byte. With rx_thr_one = 0, rxne needs at least 2 bytes.
- R8: rdata shows the oldest received byte. A rd strobe removes it. A rd on an empty receive queue changes nothing.
- R9: Each frame pushes its 8 captured bits, first bit in the MSB, into the 4-deep receive queue on the edge that ends the frame. If the queue is full at that point, the byte is lost and ovr becomes 1 and stays 1 until reset.
- R10: bsy is 1 while a frame is running or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_byte | input | 1 | Byte write strobe, enqueues wdata[7:0] |
| wr_half | input | 1 | Halfword write strobe, enqueues low then high byte |
| wdata | input | 16 | Write data |
| rd | input | 1 | Read strobe, pops the receive queue |
| rx_thr_one | input | 1 | 1: rxne at one byte, 0: at two bytes |
| miso | input | 1 | Serial data from the slave |
| rdata | output | 8 | Oldest received byte |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| txe | output | 1 | Transmit queue below half full |
| rxne | output | 1 | Receive data at or above threshold |
| bsy | output | 1 | Frame running or transmit data pending |
| ovr | output | 1 | Sticky receive overrun |

## Verification
Queue occupancy changes on the edge that takes a strobe. The flags are decoded from occupancy, so they are correct from that edge on. A frame is loaded one edge after its byte is queued, or on the edge that ends the previous frame. SCK first rises DIV/2 edges after the load. The received byte is counted 8*DIV edges after the load. A behavioural model applies these same per-edge rules to its own queues and frame timer. Every output is compared with the model 1 ns after each rising clock edge, once all registers have settled. Directed checks after each scenario confirm SCK edge counts, the dropped bytes, the threshold switch and the sticky overrun.

// File: rtl/spim_pkg.sv
// Shared constants and types for the queued SPI master.
// Assumes 8-bit frames throughout.
package spim_pkg;
    localparam int FRAME_W = 8;
    typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/spim_fifo.sv
// Circular byte queue that can take up to two entries per edge.
// Entry A is stored if one slot is free. Entry B is stored only together
// with A, and only if two slots are free. Fullness is judged on the count
// before the edge; a pop on the same edge is not credited.
// Assumes DEPTH is a power of two and at least 2.
module spim_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_a,
    input  logic [W-1:0]     data_a,
    input  logic             push_b,
    input  logic [W-1:0]     data_b,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          acc_a, acc_b, take;

    // decide which pushes and pops take effect this edge
    always_comb begin
        acc_a = push_a && (cnt < CW'(DEPTH));
        acc_b = push_b && acc_a && (cnt <= CW'(DEPTH - 2));
        take  = pop && (cnt != '0);
    end

    // storage write, no reset needed
    always_ff @(posedge clk) begin
        if (acc_a) mem[wptr] <= data_a;
        if (acc_b) mem[wptr + AW'(1)] <= data_b;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + AW'(acc_a) + AW'(acc_b);
            rptr <= rptr + AW'(take);
            cnt  <= cnt + CW'(acc_a) + CW'(acc_b) - CW'(take);
        end
    end

    assign head  = mem[rptr];
    assign count = cnt;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && pop && !push_a) |=> (cnt == '0));
endmodule

// File: rtl/spim_shift.sv
// Mode-0 shift engine: SCK idles low, MISO is captured on rising SCK and
// MOSI advances on falling SCK, MSB first. A half-period counter divides
// the system clock by DIV. A new byte is taken when idle, or on the edge
// that ends the current frame, so queued frames run back to back.
// Assumes DIV is even and at least 4.
module spim_shift
    import spim_pkg::*;
#(
    parameter int DIV = 128
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ld_ok,
    input  frame_t ld_data,
    output logic   ld_take,
    input  logic   miso,
    output logic   sck,
    output logic   mosi,
    output logic   busy,
    output logic   rx_valid,
    output frame_t rx_byte
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(HALF);
    localparam int BW   = $clog2(FRAME_W);

    logic [CW-1:0] hcnt;
    logic [BW-1:0] bitn;
    logic          sck_q, busy_q, half_end, done;
    frame_t        tsh, rsh;

    // end-of-half-period and end-of-frame decode
    always_comb begin
        half_end = busy_q && (hcnt == CW'(HALF - 1));
        done     = half_end && sck_q && (bitn == BW'(FRAME_W - 1));
        ld_take  = ld_ok && (!busy_q || done);
    end

    // divider, bit counter and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            hcnt   <= '0;
            bitn   <= '0;
            tsh    <= '0;
            rsh    <= '0;
        end else if (ld_take) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            hcnt   <= '0;
            bitn   <= '0;
            tsh    <= ld_data;
        end else if (done) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            hcnt   <= '0;
        end else if (half_end) begin
            hcnt  <= '0;
            sck_q <= !sck_q;
            if (!sck_q) begin
                rsh <= {rsh[FRAME_W-2:0], miso};
            end else begin
                bitn <= bitn + BW'(1);
                tsh  <= {tsh[FRAME_W-2:0], 1'b0};
            end
        end else if (busy_q) begin
            hcnt <= hcnt + CW'(1);
        end
    end

    assign sck      = sck_q;
    assign mosi     = busy_q && tsh[FRAME_W-1];
    assign busy     = busy_q;
    assign rx_valid = done;
    assign rx_byte  = rsh;

    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !($past(sck_q) && !sck_q)) |-> $stable(mosi));
endmodule

// File: rtl/spim_ctrl.sv
// Queued full-duplex SPI master: a transmit queue filled by byte or
// halfword writes (low byte first), a mode-0 shift engine, and a receive
// queue popped by reads. Status flags are decoded from queue occupancy.
// Assumes wr_byte and wr_half are never asserted together.
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DIV   = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_byte,
    input  logic        wr_half,
    input  logic [15:0] wdata,
    input  logic        rd,
    input  logic        rx_thr_one,
    input  logic        miso,
    output logic [7:0]  rdata,
    output logic        sck,
    output logic        mosi,
    output logic        txe,
    output logic        rxne,
    output logic        bsy,
    output logic        ovr
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] tx_cnt, rx_cnt;
    frame_t        tx_head, rx_byte;
    logic          tx_pop, rx_valid, busy, ovr_q;

    spim_fifo #(.DEPTH(DEPTH), .W(FRAME_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_a(wr_byte | wr_half), .data_a(wdata[7:0]),
        .push_b(wr_half), .data_b(wdata[15:8]),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt)
    );

    spim_shift #(.DIV(DIV)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .ld_ok(tx_cnt != '0), .ld_data(tx_head), .ld_take(tx_pop),
        .miso(miso), .sck(sck), .mosi(mosi), .busy(busy),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    spim_fifo #(.DEPTH(DEPTH), .W(FRAME_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_a(rx_valid), .data_a(rx_byte),
        .push_b(1'b0), .data_b('0),
        .pop(rd), .head(rdata), .count(rx_cnt)
    );

    // sticky record of a received byte lost to a full queue
    always_ff @(posedge clk) begin
        if (!rst_n)                                ovr_q <= 1'b0;
        else if (rx_valid && rx_cnt == CW'(DEPTH)) ovr_q <= 1'b1;
    end

    // status decode from occupancy
    always_comb begin
        txe  = tx_cnt < CW'(DEPTH / 2);
        rxne = rx_thr_one ? (rx_cnt >= CW'(1)) : (rx_cnt >= CW'(2));
        bsy  = busy || (tx_cnt != '0);
        ovr  = ovr_q;
    end

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);

    p_sck_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> bsy);
endmodule

// File: tb/sim_spim_ctrl.sv
module sim_spim_ctrl;
    localparam int DEPTH = 4;
    localparam int DIV   = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_byte = 1'b0, wr_half = 1'b0, rd = 1'b0, rx_thr_one = 1'b1;
    logic [15:0] wdata = '0;
    logic miso = 1'b0;
    logic [7:0] rdata;
    logic sck, mosi, txe, rxne, bsy, ovr;

    always #2 clk = !clk;

    spim_ctrl #(.DEPTH(DEPTH), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_byte(wr_byte), .wr_half(wr_half),
        .wdata(wdata), .rd(rd), .rx_thr_one(rx_thr_one), .miso(miso),
        .rdata(rdata), .sck(sck), .mosi(mosi), .txe(txe), .rxne(rxne),
        .bsy(bsy), .ovr(ovr)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // MISO source: 0 constant, 1 constant, 2 pseudo-random
    int miso_mode = 0;
    logic [7:0] lfsr = 8'hA7;
    int mcnt = 0;
    always @(negedge clk) begin
        mcnt++;
        if (mcnt % 37 == 0) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        miso <= (miso_mode == 2) ? lfsr[0] : (miso_mode == 1);
    end

    // behavioural reference model
    logic [7:0] m_txq[$];
    logic [7:0] m_rxq[$];
    bit m_busy = 0, m_ovr = 0, m_started = 0, m_done;
    int m_timer = 0, m_free, m_rxn, m_txn;
    logic [7:0] m_tx = 0, m_rsh = 0;

    always @(posedge clk) begin
        m_started = 1;
        if (!rst_n) begin
            m_txq.delete(); m_rxq.delete();
            m_busy = 0; m_ovr = 0; m_timer = 0; m_tx = 0; m_rsh = 0;
        end else begin
            m_done = m_busy && (m_timer == 8 * DIV - 1);
            m_free = DEPTH - m_txq.size();
            m_rxn  = m_rxq.size();
            m_txn  = m_txq.size();
            if (m_busy && ((m_timer + 1) % DIV) == DIV / 2) m_rsh = {m_rsh[6:0], miso};
            if (m_done && m_rxn == DEPTH) m_ovr = 1;
            if (rd && m_rxn > 0) void'(m_rxq.pop_front());
            if (m_done && m_rxn < DEPTH) m_rxq.push_back(m_rsh);
            if ((!m_busy || m_done) && m_txn > 0) begin
                m_tx = m_txq.pop_front(); m_busy = 1; m_timer = 0;
            end else if (m_done) begin
                m_busy = 0; m_timer = 0;
            end else if (m_busy) begin
                m_timer++;
            end
            if ((wr_byte || wr_half) && m_free >= 1) m_txq.push_back(wdata[7:0]);
            if (wr_half && m_free >= 2) m_txq.push_back(wdata[15:8]);
        end
    end

    // per-cycle comparison 1 ns after each edge, plus SCK rise counter
    int sck_rises = 0;
    logic sck_prev = 0;
    bit e_sck, e_mosi, e_rxne;
    always @(posedge clk) begin
        #1;
        if (m_started) begin
            e_sck  = m_busy && ((m_timer % DIV) >= DIV / 2);
            e_mosi = m_busy && m_tx[7 - m_timer / DIV];
            e_rxne = rx_thr_one ? (m_rxq.size() >= 1) : (m_rxq.size() >= 2);
            check(sck == e_sck, "R2 sck", int'(sck), int'(e_sck));
            check(mosi == e_mosi, "R3 mosi", int'(mosi), int'(e_mosi));
            check(txe == (m_txq.size() < 2), "R6 txe", int'(txe), int'(m_txq.size() < 2));
            check(rxne == e_rxne, "R7 rxne", int'(rxne), int'(e_rxne));
            check(bsy == (m_busy || m_txq.size() != 0), "R10 bsy", int'(bsy),
                  int'(m_busy || m_txq.size() != 0));
            check(ovr == m_ovr, "R9 ovr", int'(ovr), int'(m_ovr));
            if (m_rxq.size() > 0) check(rdata == m_rxq[0], "R8 rdata", int'(rdata), int'(m_rxq[0]));
            if (sck && !sck_prev) sck_rises++;
            sck_prev = sck;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy || m_txq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    int base;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!sck && !mosi, "R1 sck/mosi", int'({sck, mosi}), 0);
        check(txe && !rxne && !bsy && !ovr, "R1 flags",
              int'({txe, rxne, bsy, ovr}), 4'b1000);

        // R2 R3: single byte, MISO held high
        miso_mode = 1; rx_thr_one = 1'b1;
        base = sck_rises;
        @(negedge clk) begin wr_byte = 1'b1; wdata = 16'h0055; end
        @(negedge clk) wr_byte = 1'b0;
        wait_idle();
        check(sck_rises - base == 8, "R2 sck periods", sck_rises - base, 8);
        check(rxne == 1'b1, "R7 one-byte threshold", int'(rxne), 1);
        check(rdata == 8'hFF, "R9 captured byte", int'(rdata), 8'hFF);
        pulse_rd();
        @(negedge clk);
        check(rxne == 1'b0, "R8 pop", int'(rxne), 0);

        // R4: halfword, random MISO, two-byte threshold
        miso_mode = 2; rx_thr_one = 1'b0;
        base = sck_rises;
        @(negedge clk) begin wr_half = 1'b1; wdata = 16'hA53C; end
        @(negedge clk) wr_half = 1'b0;
        wait_idle();
        check(sck_rises - base == 16, "R4 two frames", sck_rises - base, 16);
        check(rxne == 1'b1, "R7 two-byte threshold", int'(rxne), 1);
        pulse_rd();
        @(negedge clk);
        check(rxne == 1'b0, "R7 one byte below threshold", int'(rxne), 0);
        rx_thr_one = 1'b1;
        @(negedge clk);
        check(rxne == 1'b1, "R7 threshold switch", int'(rxne), 1);
        pulse_rd();
        pulse_rd();  // R8: read on empty queue
        @(negedge clk);
        check(rxne == 1'b0, "R8 empty read", int'(rxne), 0);

        // R5 R6 R9: overfill the transmit queue, overrun the receive queue
        miso_mode = 1;
        base = sck_rises;
        @(negedge clk) begin wr_half = 1'b1; wdata = 16'h1122; end
        @(negedge clk) wdata = 16'h3344;
        @(negedge clk) wdata = 16'h5566;
        @(negedge clk) begin wr_half = 1'b0; wr_byte = 1'b1; wdata = 16'h0077; end
        @(negedge clk) wr_byte = 1'b0;
        check(txe == 1'b0, "R6 queue half full", int'(txe), 0);
        check(bsy == 1'b1, "R10 busy", int'(bsy), 1);
        wait_idle();
        check(sck_rises - base == 40, "R5 dropped bytes", sck_rises - base, 40);
        check(ovr == 1'b1, "R9 overrun", int'(ovr), 1);
        for (int i = 0; i < 4; i++) begin
            check(rdata == 8'hFF, "R9 stored byte", int'(rdata), 8'hFF);
            pulse_rd();
        end
        @(negedge clk);
        check(rxne == 1'b0, "R8 drained", int'(rxne), 0);
        check(ovr == 1'b1, "R9 sticky", int'(ovr), 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule